// File: doc/BRIEF.md
# Status Register and Write Permit Unit

This block keeps the 8-bit status byte of a serial nonvolatile memory and decides, byte by byte, whether a write is allowed. The serial command decoder feeds it single-cycle strobes. These strobes mark when a command has been recognised: latch enable, latch disable, status write, or memory write (single or dual lane). The decoder also strobes each status data byte and each rise of chip select. The block answers with the status byte for readback and with two permits: one for the memory byte at the current target address, and one for the status data byte. The counter commands do not pass through this unit. The nonvolatile bits are modelled as plain flip-flops that reset to zero.

The core is a three-state machine. `ST_IDLE` means no write command is open. `ST_SR_OPEN` is entered from `ST_IDLE` on a status-write strobe, and at that moment the level of the protect pin is captured. `ST_MEM_OPEN` is entered from `ST_IDLE` on a memory-write strobe. Both open states return to `ST_IDLE` on the chip-select rise, and that transition also clears the write-enable latch. A chip-select rise in `ST_IDLE` leaves the state where it is.

Status layout: bit 7 is the pin-protect enable (PE). Bits 6..4 are spare, and they can be written and read. Bits 3..2 are the block-protect field BP (bit 3 is the high bit). Bit 1 is the write-enable latch (WEL). Bit 0 always reads 0.

Top module: `spr_unit`

## Requirements
- R1: After reset the status byte reads 0x00 and both permits are low.
- R2: A latch-enable strobe sets status bit 1 on the next clock edge. A latch-disable strobe clears it.
- R3: An accepted status data byte loads bits 7..2 from data bits 7..2. Data bits 1 and 0 are discarded: bit 1 keeps the latch value and bit 0 stays 0.
- R4: The status permit is high only in `ST_SR_OPEN` with WEL=1, and never when PE (bit 7)=1 and the captured pin level is 0. A status data byte that arrives while the permit is low leaves the status byte unchanged.
- R5: The protect pin level is captured once, on the status-write strobe. Changing the pin later in the same command has no effect on the status permit.
- R6: The memory permit is high only in `ST_MEM_OPEN` with WEL=1, and only when the address lies outside the protected range. The range is set by BP (bits 3..2): 00 protects nothing, 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF, and 11 protects the whole array.
- R7: The memory permit follows the address in the same cycle. A burst that crosses into a protected range loses the permit at the first protected byte.
- R8: A chip-select rise while a status-write or memory-write command is open clears WEL and returns to `ST_IDLE`. A chip-select rise after any other command leaves WEL unchanged.
- R9: In `ST_IDLE` both permits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wren_stb_i | input | 1 | Latch-enable command recognised |
| wrdi_stb_i | input | 1 | Latch-disable command recognised |
| srwr_stb_i | input | 1 | Status-write command recognised |
| memwr_stb_i | input | 1 | Memory-write command (single or dual lane) recognised |
| srdat_vld_i | input | 1 | Status data byte present |
| srdat_i | input | 8 | Status data byte |
| cs_rise_i | input | 1 | Chip select rose |
| wp_n_i | input | 1 | Protect pin level (0 = protect) |
| addr_i | input | 11 | Target byte address of the pending memory write |
| status_o | output | 8 | Status byte for readback |
| mem_wr_ok_o | output | 1 | Memory byte write permitted |
| sr_wr_ok_o | output | 1 | Status byte write permitted |

## Verification
A wrong state or a wrong latch value shows up at the ports at once. The status readback reflects it one edge after the strobe that caused it. The combinational permits reflect it in the same cycle as the offending address or data byte, so every check samples one cycle after a stimulus. A stale captured pin level is invisible until a status data byte arrives with PE set. The checks therefore change the pin inside an open status-write command and compare the permit. The BP boundaries 0x3FF/0x400 and 0x5FF/0x600 are exercised directly, because an off-by-one in range decoding shows only there.

// File: rtl/spr_pkg.sv
package spr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SR_OPEN  = 2'd1,
        ST_MEM_OPEN = 2'd2
    } spr_state_t;

    localparam int SR_W     = 8;
    localparam int BIT_PE   = 7;
    localparam int BIT_BPHI = 3;
    localparam int BIT_BPLO = 2;
    localparam int BIT_WEL  = 1;
endpackage

// File: rtl/spr_fsm.sv
module spr_fsm
    import spr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic srwr_stb_i,
    input  logic memwr_stb_i,
    input  logic cs_rise_i,
    input  logic wp_n_i,
    output logic sr_open_o,
    output logic mem_open_o,
    output logic wel_clr_o,
    output logic wp_cap_o
);
    spr_state_t state_q, state_d;
    logic       wp_cap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_rise_i) begin
                    if (srwr_stb_i)       state_d = ST_SR_OPEN;
                    else if (memwr_stb_i) state_d = ST_MEM_OPEN;
                end
            end
            ST_SR_OPEN:  if (cs_rise_i) state_d = ST_IDLE;
            ST_MEM_OPEN: if (cs_rise_i) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= ST_IDLE;
            wp_cap_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_SR_OPEN)
                wp_cap_q <= wp_n_i;
        end
    end

    always_comb begin
        sr_open_o  = (state_q == ST_SR_OPEN);
        mem_open_o = (state_q == ST_MEM_OPEN);
        wel_clr_o  = cs_rise_i && (state_q != ST_IDLE);
        wp_cap_o   = wp_cap_q;
    end

    // R5: captured pin level stays fixed while the status command is open
    a_r5_wp_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SR_OPEN && !cs_rise_i) |=> $stable(wp_cap_q));
    // R8: chip-select rise closes any open command
    a_r8_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_rise_i && state_q != ST_IDLE) |=> state_q == ST_IDLE);
endmodule

// File: rtl/spr_regs.sv
module spr_regs
    import spr_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wren_stb_i,
    input  logic            wrdi_stb_i,
    input  logic            wel_clr_i,
    input  logic            load_i,
    input  logic [SR_W-1:0] data_i,
    output logic [SR_W-1:0] status_o
);
    logic [SR_W-1:2] upper_q;
    logic            wel_q;
    logic            unused_low;

    assign unused_low = ^data_i[1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            upper_q <= '0;
            wel_q   <= 1'b0;
        end else begin
            if (load_i) upper_q <= data_i[SR_W-1:2];
            if (wel_clr_i)       wel_q <= 1'b0;
            else if (wrdi_stb_i) wel_q <= 1'b0;
            else if (wren_stb_i) wel_q <= 1'b1;
        end
    end

    assign status_o = {upper_q, wel_q, 1'b0};

    // R2: latch enable sets WEL unless the command is being closed
    a_r2_wren_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wren_stb_i && !wrdi_stb_i && !wel_clr_i) |=> status_o[BIT_WEL]);
    // R8: closing a write command drops WEL
    a_r8_wel_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wel_clr_i |=> !status_o[BIT_WEL]);
    // R4: no load means the writable bits hold
    a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(status_o[SR_W-1:2]));
endmodule

// File: rtl/spr_guard.sv
module spr_guard
    import spr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SR_W-1:0]   status_i,
    input  logic              sr_open_i,
    input  logic              mem_open_i,
    input  logic              wp_cap_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              mem_ok_o,
    output logic              sr_ok_o
);
    logic [1:0] bp;
    logic       in_prot;
    logic       wel;
    logic       pe;

    assign bp  = status_i[BIT_BPHI:BIT_BPLO];
    assign wel = status_i[BIT_WEL];
    assign pe  = status_i[BIT_PE];

    always_comb begin
        unique case (bp)
            2'b00:   in_prot = 1'b0;
            2'b01:   in_prot = (addr_i[ADDR_W-1:ADDR_W-2] == 2'b11);
            2'b10:   in_prot = addr_i[ADDR_W-1];
            default: in_prot = 1'b1;
        endcase
    end

    assign mem_ok_o = mem_open_i && wel && !in_prot;
    assign sr_ok_o  = sr_open_i && wel && !(pe && !wp_cap_i);

    // R6: whole-array protection never permits a memory write
    a_r6_all_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bp == 2'b11) |-> !mem_ok_o);
    // R9: permits only inside an open command
    a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sr_open_i && !mem_open_i) |-> !(mem_ok_o || sr_ok_o));
endmodule

// File: rtl/spr_unit.sv
module spr_unit
    import spr_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wren_stb_i,
    input  logic        wrdi_stb_i,
    input  logic        srwr_stb_i,
    input  logic        memwr_stb_i,
    input  logic        srdat_vld_i,
    input  logic [7:0]  srdat_i,
    input  logic        cs_rise_i,
    input  logic        wp_n_i,
    input  logic [10:0] addr_i,
    output logic [7:0]  status_o,
    output logic        mem_wr_ok_o,
    output logic        sr_wr_ok_o
);
    localparam int ADDR_W = 11;

    logic sr_open, mem_open, wel_clr, wp_cap;
    logic sr_ok, mem_ok, load;
    logic [SR_W-1:0] status;

    spr_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .srwr_stb_i (srwr_stb_i),
        .memwr_stb_i(memwr_stb_i),
        .cs_rise_i  (cs_rise_i),
        .wp_n_i     (wp_n_i),
        .sr_open_o  (sr_open),
        .mem_open_o (mem_open),
        .wel_clr_o  (wel_clr),
        .wp_cap_o   (wp_cap)
    );

    assign load = srdat_vld_i && sr_ok;

    spr_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wren_stb_i(wren_stb_i),
        .wrdi_stb_i(wrdi_stb_i),
        .wel_clr_i (wel_clr),
        .load_i    (load),
        .data_i    (srdat_i),
        .status_o  (status)
    );

    spr_guard #(.ADDR_W(ADDR_W)) u_guard (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .status_i  (status),
        .sr_open_i (sr_open),
        .mem_open_i(mem_open),
        .wp_cap_i  (wp_cap),
        .addr_i    (addr_i),
        .mem_ok_o  (mem_ok),
        .sr_ok_o   (sr_ok)
    );

    assign status_o    = status;
    assign mem_wr_ok_o = mem_ok;
    assign sr_wr_ok_o  = sr_ok;

    // R3: a rejected data byte must not reach the register
    a_r3_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (srdat_vld_i && !sr_wr_ok_o) |=> $stable(status_o));
endmodule

// File: tb/spr_unit_tb_top.sv
module spr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren = 0, wrdi = 0, srwr = 0, memwr = 0, dvld = 0, csr = 0;
    logic        wp_n = 1'b1;
    logic [7:0]  dat = '0;
    logic [10:0] addr = '0;
    logic [7:0]  status;
    logic        mem_ok, sr_ok;

    int n_chk = 0;
    int n_bad = 0;

    // model: 0 idle, 1 status open, 2 memory open
    int         m_st = 0;
    logic       m_wel = 0;
    logic [5:0] m_up = '0;
    logic       m_wp = 1'b1;

    always #10 clk = ~clk;

    spr_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .wren_stb_i(wren), .wrdi_stb_i(wrdi), .srwr_stb_i(srwr),
        .memwr_stb_i(memwr), .srdat_vld_i(dvld), .srdat_i(dat),
        .cs_rise_i(csr), .wp_n_i(wp_n), .addr_i(addr),
        .status_o(status), .mem_wr_ok_o(mem_ok), .sr_wr_ok_o(sr_ok)
    );

    function automatic logic [7:0] exp_status();
        return {m_up, m_wel, 1'b0};
    endfunction

    function automatic logic prot(logic [1:0] bp, logic [10:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 11'h600;
            2'b10:   return a >= 11'h400;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic exp_mem_ok(logic [10:0] a);
        return (m_st == 2) && m_wel && !prot(m_up[1:0], a);
    endfunction

    function automatic logic exp_sr_ok();
        return (m_st == 1) && m_wel && !(m_up[5] && !m_wp);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, status, exp_status());
        chk(req, {7'd0, sr_ok}, {7'd0, exp_sr_ok()});
        chk(req, {7'd0, mem_ok}, {7'd0, exp_mem_ok(addr)});
    endtask

    // op: 0 enable,1 disable,2 status cmd,3 mem cmd,4 data,5 cs rise
    task automatic do_op(int op, logic [7:0] d);
        logic ok_before;
        ok_before = exp_sr_ok();
        case (op)
            0: wren = 1;
            1: wrdi = 1;
            2: srwr = 1;
            3: memwr = 1;
            4: begin dvld = 1; dat = d; end
            default: csr = 1;
        endcase
        @(negedge clk);
        wren = 0; wrdi = 0; srwr = 0; memwr = 0; dvld = 0; csr = 0;
        case (op)
            0: m_wel = 1;
            1: m_wel = 0;
            2: if (m_st == 0) begin m_st = 1; m_wp = wp_n; end
            3: if (m_st == 0) m_st = 2;
            4: if (ok_before) m_up = d[7:2];
            default: begin if (m_st != 0) m_wel = 0; m_st = 0; end
        endcase
        #1;
    endtask

    task automatic probe(string req, logic [10:0] a);
        addr = a;
        #1;
        chk(req, {7'd0, mem_ok}, {7'd0, exp_mem_ok(a)});
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2, R3: accepted byte, low bits discarded
        do_op(0, 0); check_all("R2");
        do_op(2, 0); check_all("R9");
        do_op(4, 8'hFF); chk("R3", status, 8'hFE);
        do_op(5, 0); chk("R8", status, 8'hFC);
        do_op(1, 0); chk("R2", status, 8'hFC);
        do_op(5, 0); chk("R8", status, 8'hFC);  // cs rise in idle keeps state
        do_op(0, 0); do_op(5, 0); chk("R8", status, 8'hFE); // WEL kept after enable cmd

        // R4/R5: PE set, pin low captured, later raised
        wp_n = 1'b0;
        do_op(2, 0); chk("R4", {7'd0, sr_ok}, 8'h00);
        wp_n = 1'b1; #1;
        chk("R5", {7'd0, sr_ok}, 8'h00);
        do_op(4, 8'h00); chk("R4", status, 8'hFE);
        do_op(5, 0); chk("R8", status, 8'hFC);
        // pin high captured: write allowed even if pin drops later
        do_op(0, 0); do_op(2, 0);
        wp_n = 1'b0; #1;
        chk("R5", {7'd0, sr_ok}, 8'h01);
        do_op(4, 8'h84); chk("R3", status, 8'h86);
        do_op(5, 0); wp_n = 1'b1;

        // R6/R7: BP boundaries for each code
        for (int bpv = 0; bpv < 4; bpv++) begin
            do_op(0, 0); do_op(2, 0);
            do_op(4, {4'h0, bpv[1:0], 2'b00});
            do_op(5, 0);
            do_op(0, 0); do_op(3, 0);
            probe("R6", 11'h000); probe("R6", 11'h3FF); probe("R6", 11'h400);
            probe("R7", 11'h5FF); probe("R7", 11'h600); probe("R6", 11'h7FF);
            do_op(5, 0);
            probe("R9", 11'h000);
        end

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom_range(0, 6));
            if (op == 6) begin wp_n = ~wp_n; #1; end
            else do_op(op, 8'($urandom));
            addr = 11'($urandom);
            #1;
            check_all("R6");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule